// File: doc/BRIEF.md
# Timestamp Capture, Compare and Pulse Unit

This unit sits beside a free-running time counter and watches its seconds and nanoseconds words. It offers three time-based services. First, it takes a snapshot of the full time when a selected edge appears on an asynchronous trigger pin. Second, it flags an event once the time reaches a programmed target. Third, it emits a one-cycle pulse each time the sub-second part crosses a boundary that splits the second into 2^p equal slots.

Each service sets a sticky status bit. Software clears a status bit by writing 1 to it. An enable mask selects which status bits drive the interrupt line. Software reaches the unit through a simple write port. The snapshot, the status vector and the compare armed flag are plain outputs that always show the current register contents. No stream interface is involved, so there is no back-pressure to honour.

Top module: `ts_event_unit`

## Requirements
- R1: Capture edge selection comes from the config register (address 0). Bit 0 enables capture on rising trigger edges and bit 1 on falling edges. Both bits set captures on either edge, and neither set captures nothing.
- R2: The trigger passes two synchronizer flops and one edge-detect flop. A capture latches both time words as they stand at the third clock edge after the pin changes, and sets status bit 1.
- R3: With the hold bit (config bit 2) clear, every qualifying edge overwrites the snapshot.
- R4: With the hold bit set, a snapshot stays frozen while status bit 1 is set. Once software clears that bit, the next qualifying edge captures again.
- R5: Target seconds go to address 1 and target nanoseconds to address 2. Writing 1 to bit 0 of address 3 arms the compare. While armed, the first cycle with time >= target sets status bit 0 and disarms the compare, so it fires only once.
- R6: Status bits are sticky: bit 0 is compare, bit 1 is capture and bit 2 is pulse. Writing 1 to a bit at address 4 clears it. If a new event arrives in the same cycle as the clear, the event wins.
- R7: The interrupt line is high exactly when some status bit is set and its enable bit in address 5 (same bit order) is also set.
- R8: With rate exponent p in config bits 7:4, the pulse output goes high for one cycle after each cycle in which the nanoseconds cross k*10^9/2^p (k = 1..2^p-1), and after each change of the seconds word. Each pulse sets status bit 2.
- R9: After reset, and after any change of p, the pulse output stays low until the seconds word next changes, whatever the nanoseconds do.
- R10: After reset the snapshot, status, armed flag, pulse and interrupt outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tm_sec_i | input | SEC_W | Current time, seconds |
| tm_ns_i | input | NS_W | Current time, nanoseconds |
| trig_i | input | 1 | Asynchronous capture trigger |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| cap_sec_o | output | SEC_W | Snapshot seconds |
| cap_ns_o | output | NS_W | Snapshot nanoseconds |
| sts_o | output | 3 | Sticky status {pulse, capture, compare} |
| cmp_armed_o | output | 1 | Compare armed flag |
| pps_o | output | 1 | Rate pulse |
| irq_o | output | 1 | Interrupt |

## Verification
Each internal fault shows up at the ports in a known way:
- A wrong edge-detect or synchronizer state moves or drops a snapshot. This is visible three cycles after the pin changes, as a missing or extra change on the snapshot outputs.
- A stuck armed flag shows as a second compare event after the status is cleared, and it appears on the next cycle.
- A wrong slot counter or boundary accumulator in the pulse generator shifts the pulses by one slot within a single second, or fires them right after a rate change.
- A stray hold flag leaves the snapshot frozen after a status clear, and the next trigger reveals it.

// File: rtl/ts_event_pkg.sv
package ts_event_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int N_EV   = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TSEC = 3'd1;
  localparam logic [ADDR_W-1:0] A_TNS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ARM  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;

  localparam int EV_CMP = 0;
  localparam int EV_CAP = 1;
  localparam int EV_PPS = 2;

  localparam int CFG_RISE  = 0;
  localparam int CFG_FALL  = 1;
  localparam int CFG_KEEP  = 2;
  localparam int CFG_P_LSB = 4;

  typedef struct packed {
    logic keep;
    logic fall;
    logic rise;
  } cap_cfg_t;
endpackage

// File: rtl/ts_capture.sv
module ts_capture
  import ts_event_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  cap_cfg_t         cfg_i,
  input  logic             held_i,
  input  logic [SEC_W-1:0] tm_sec_i,
  input  logic [NS_W-1:0]  tm_ns_i,
  output logic [SEC_W-1:0] cap_sec_o,
  output logic [NS_W-1:0]  cap_ns_o,
  output logic             ev_o
);
  // sh[SYNC_N-1] is the synchronized level, sh[SYNC_N] its previous value
  logic [SYNC_N:0] sh_q;
  logic rise, fall, take;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], trig_i};
  end

  assign rise = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
  assign fall = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
  assign ev_o = (cfg_i.rise & rise) | (cfg_i.fall & fall);
  assign take = ev_o & ~(cfg_i.keep & held_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cap_sec_o <= '0;
      cap_ns_o  <= '0;
    end else if (take) begin
      cap_sec_o <= tm_sec_i;
      cap_ns_o  <= tm_ns_i;
    end
  end
endmodule

// File: rtl/ts_compare.sv
module ts_compare #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_sec_i,
  input  logic             ld_ns_i,
  input  logic             arm_i,
  input  logic [SEC_W-1:0] ld_val_sec_i,
  input  logic [NS_W-1:0]  ld_val_ns_i,
  input  logic [SEC_W-1:0] tm_sec_i,
  input  logic [NS_W-1:0]  tm_ns_i,
  output logic             armed_o,
  output logic             ev_o
);
  logic [SEC_W-1:0] tgt_sec_q;
  logic [NS_W-1:0]  tgt_ns_q;
  logic             reached;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tgt_sec_q <= '0;
      tgt_ns_q  <= '0;
    end else begin
      if (ld_sec_i) tgt_sec_q <= ld_val_sec_i;
      if (ld_ns_i)  tgt_ns_q  <= ld_val_ns_i;
    end
  end

  assign reached = (tm_sec_i > tgt_sec_q) ||
                   ((tm_sec_i == tgt_sec_q) && (tm_ns_i >= tgt_ns_q));
  assign ev_o = armed_o & reached;

  // a fresh arm request outranks the self-clear of the same cycle
  always_ff @(posedge clk_i) begin
    if (!rst_ni)    armed_o <= 1'b0;
    else if (arm_i) armed_o <= 1'b1;
    else if (ev_o)  armed_o <= 1'b0;
  end
endmodule

// File: rtl/ts_pps.sv
module ts_pps #(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int P_W        = 4,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [P_W-1:0]   p_i,
  input  logic [SEC_W-1:0] tm_sec_i,
  input  logic [NS_W-1:0]  tm_ns_i,
  output logic             pps_o,
  output logic             ev_o
);
  localparam int PMAX  = (1 << P_W) - 1;
  localparam int SCL_W = NS_W + PMAX + 1;
  localparam int KW    = PMAX + 2;
  localparam logic [SCL_W-1:0] NS_STEP = SCL_W'(NS_PER_SEC);

  logic [P_W-1:0]   p_last_q;
  logic             synced_q, prev_vld_q;
  logic [SEC_W-1:0] prev_sec_q;
  logic [KW-1:0]    slot_q;
  logic [SCL_W-1:0] bnd_q;

  logic [SCL_W-1:0] scaled;
  logic [KW-1:0]    n_slots;
  logic rate_chg, sec_step, sub_hit;

  // compare ns * 2^p against k * NS_PER_SEC to avoid a divider
  assign scaled   = {{(SCL_W-NS_W){1'b0}}, tm_ns_i} << p_i;
  assign n_slots  = KW'(1) << p_i;
  assign rate_chg = (p_i != p_last_q);
  assign sec_step = prev_vld_q && (tm_sec_i != prev_sec_q);
  assign sub_hit  = synced_q && (slot_q < n_slots) && (scaled >= bnd_q);
  assign ev_o     = !rate_chg && (sec_step || sub_hit);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_last_q   <= '0;
      synced_q   <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_sec_q <= '0;
      slot_q     <= '0;
      bnd_q      <= '0;
      pps_o      <= 1'b0;
    end else begin
      p_last_q   <= p_i;
      prev_vld_q <= 1'b1;
      prev_sec_q <= tm_sec_i;
      pps_o      <= ev_o;
      if (rate_chg) begin
        synced_q <= 1'b0;
      end else if (sec_step) begin
        synced_q <= 1'b1;
        slot_q   <= KW'(1);
        bnd_q    <= NS_STEP;
      end else if (sub_hit) begin
        slot_q   <= slot_q + KW'(1);
        bnd_q    <= bnd_q + NS_STEP;
      end
    end
  end
endmodule

// File: rtl/ts_event_unit.sv
module ts_event_unit
  import ts_event_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int P_W        = 4,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEC_W-1:0]  tm_sec_i,
  input  logic [NS_W-1:0]   tm_ns_i,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SEC_W-1:0]  cap_sec_o,
  output logic [NS_W-1:0]   cap_ns_o,
  output logic [N_EV-1:0]   sts_o,
  output logic              cmp_armed_o,
  output logic              pps_o,
  output logic              irq_o
);
  cap_cfg_t        cfg_q;
  logic [P_W-1:0]  rate_q;
  logic [N_EV-1:0] ien_q, set_v, clr_v;
  logic            wr_cfg, wr_clr, wr_ien;
  logic            ev_cap, ev_cmp, ev_pps;

  assign wr_cfg = wr_en_i && (wr_addr_i == A_CFG);
  assign wr_clr = wr_en_i && (wr_addr_i == A_CLR);
  assign wr_ien = wr_en_i && (wr_addr_i == A_IEN);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      rate_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q.rise <= wr_data_i[CFG_RISE];
        cfg_q.fall <= wr_data_i[CFG_FALL];
        cfg_q.keep <= wr_data_i[CFG_KEEP];
        rate_q     <= wr_data_i[CFG_P_LSB +: P_W];
      end
      if (wr_ien) ien_q <= wr_data_i[N_EV-1:0];
    end
  end

  ts_capture #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .cfg_i(cfg_q),
    .held_i(sts_o[EV_CAP]), .tm_sec_i(tm_sec_i), .tm_ns_i(tm_ns_i),
    .cap_sec_o(cap_sec_o), .cap_ns_o(cap_ns_o), .ev_o(ev_cap)
  );

  ts_compare #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_sec_i(wr_en_i && (wr_addr_i == A_TSEC)),
    .ld_ns_i(wr_en_i && (wr_addr_i == A_TNS)),
    .arm_i(wr_en_i && (wr_addr_i == A_ARM) && wr_data_i[0]),
    .ld_val_sec_i(wr_data_i[SEC_W-1:0]), .ld_val_ns_i(wr_data_i[NS_W-1:0]),
    .tm_sec_i(tm_sec_i), .tm_ns_i(tm_ns_i),
    .armed_o(cmp_armed_o), .ev_o(ev_cmp)
  );

  ts_pps #(.SEC_W(SEC_W), .NS_W(NS_W), .P_W(P_W), .NS_PER_SEC(NS_PER_SEC)) u_pps (
    .clk_i(clk_i), .rst_ni(rst_ni), .p_i(rate_q),
    .tm_sec_i(tm_sec_i), .tm_ns_i(tm_ns_i), .pps_o(pps_o), .ev_o(ev_pps)
  );

  always_comb begin
    set_v         = '0;
    set_v[EV_CMP] = ev_cmp;
    set_v[EV_CAP] = ev_cap;
    set_v[EV_PPS] = ev_pps;
    clr_v         = wr_clr ? wr_data_i[N_EV-1:0] : '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_v) | set_v;
  end

  assign irq_o = |(sts_o & ien_q);
endmodule

// File: rtl/ts_event_unit_chk.sv
module ts_event_unit_chk
  import ts_event_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [N_EV-1:0]   sts,
  input logic [SEC_W-1:0]  cap_sec,
  input logic [NS_W-1:0]   cap_ns,
  input logic              keep,
  input logic              armed,
  input logic              pps,
  input logic              irq
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == A_CLR);

  for (genvar i = 0; i < N_EV; i++) begin : g_sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sts[i]) && !($past(clr_wr) && $past(wr_data[i]))) |-> sts[i]);
  end

  a_r4_keep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(keep) && $past(sts[EV_CAP])) |-> ($stable(cap_sec) && $stable(cap_ns)));

  a_r5_disarm_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> sts[EV_CMP]);

  a_r8_pulse_status: assert property (@(posedge clk) disable iff (!rst_n)
    pps |-> sts[EV_PPS]);

  a_r7_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> !irq);
endmodule

bind ts_event_unit ts_event_unit_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
  .wr_data(wr_data_i), .sts(sts_o), .cap_sec(cap_sec_o), .cap_ns(cap_ns_o),
  .keep(cfg_q.keep), .armed(cmp_armed_o), .pps(pps_o), .irq(irq_o)
);

// File: tb/sim_ts_event_unit.sv
module sim_ts_event_unit;
  import ts_event_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tm_sec = '0;
  logic [29:0] tm_ns = '0;
  logic        trig = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cap_sec;
  logic [29:0] cap_ns;
  logic [2:0]  sts;
  logic        armed, pps, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] s; logic [29:0] n; } snap_t;
  snap_t exp_q[$];
  logic [31:0] seen_s = '0;
  logic [29:0] seen_n = '0;

  always #2.5 clk = ~clk;

  ts_event_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .tm_sec_i(tm_sec), .tm_ns_i(tm_ns),
    .trig_i(trig), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cap_sec_o(cap_sec), .cap_ns_o(cap_ns), .sts_o(sts),
    .cmp_armed_o(armed), .pps_o(pps), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every change of the snapshot must match the next queued item
  always @(negedge clk) begin
    if (rst_n && !done && (cap_sec != seen_s || cap_ns != seen_n)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3/R4", "unexpected snapshot sec", cap_sec, seen_s);
      end else begin
        snap_t e;
        e = exp_q.pop_front();
        chk(cap_sec == e.s && cap_ns == e.n, "R2", "snapshot sec*1e9+ns",
            longint'(cap_sec) * 1000000000 + cap_ns, longint'(e.s) * 1000000000 + e.n);
      end
      seen_s = cap_sec;
      seen_n = cap_ns;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_tm(input logic [31:0] s, input logic [29:0] n);
    tm_sec = s; tm_ns = n;
  endtask

  task automatic drive_trig(input logic lvl, input bit expect_cap);
    snap_t e;
    trig = lvl;
    if (expect_cap) begin
      e.s = tm_sec; e.n = tm_ns;
      exp_q.push_back(e);
    end
    idle(4);
  endtask

  task automatic step(input logic [31:0] s, input logic [29:0] n, input bit exp_p);
    set_tm(s, n);
    @(negedge clk);
    chk(pps == exp_p, "R8/R9", "pulse", pps, exp_p);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk(sts == 0 && armed == 0 && irq == 0 && pps == 0, "R10", "status/armed/irq/pulse", {sts, armed, irq, pps}, 0);
    chk(cap_sec == 0 && cap_ns == 0, "R10", "snapshot", cap_ns, 0);

    // R1/R2 rising only
    wr(A_CFG, 32'h1);
    set_tm(5, 100);  drive_trig(1, 1);
    chk(sts[EV_CAP] == 1, "R2", "capture status", sts[EV_CAP], 1);
    set_tm(5, 200);  drive_trig(0, 0);
    chk(cap_ns == 100, "R1", "falling ignored in rise mode", cap_ns, 100);
    // R1 falling only, R3 overwrite
    wr(A_CFG, 32'h2);
    set_tm(6, 300);  drive_trig(1, 0);
    chk(cap_ns == 100, "R1", "rising ignored in fall mode", cap_ns, 100);
    set_tm(6, 310);  drive_trig(0, 1);
    chk(cap_ns == 310, "R3", "overwrite", cap_ns, 310);
    // R1 both edges
    wr(A_CFG, 32'h3);
    set_tm(7, 400);  drive_trig(1, 1);
    set_tm(7, 500);  drive_trig(0, 1);
    chk(cap_sec == 7 && cap_ns == 500, "R1", "both edges", cap_ns, 500);
    // R1 none
    wr(A_CFG, 32'h0);
    set_tm(8, 1);    drive_trig(1, 0);
    drive_trig(0, 0);
    chk(cap_ns == 500, "R1", "no edge enabled", cap_ns, 500);

    // R4 hold mode
    wr(A_CLR, 32'h2);
    chk(sts[EV_CAP] == 0, "R6", "capture status cleared", sts[EV_CAP], 0);
    wr(A_CFG, 32'h5);
    set_tm(9, 10);   drive_trig(1, 1);
    drive_trig(0, 0);
    set_tm(9, 20);   drive_trig(1, 0);
    chk(cap_ns == 10, "R4", "held snapshot", cap_ns, 10);
    drive_trig(0, 0);
    wr(A_CLR, 32'h2);
    set_tm(9, 30);   drive_trig(1, 1);
    chk(cap_ns == 30, "R4", "released snapshot", cap_ns, 30);

    // R5 compare
    wr(A_TSEC, 10);
    wr(A_TNS, 500);
    set_tm(10, 499);
    wr(A_ARM, 1);
    idle(2);
    chk(armed == 1 && sts[EV_CMP] == 0, "R5", "armed, not reached", {armed, sts[EV_CMP]}, 2);
    set_tm(10, 500);
    idle(1);
    chk(armed == 0 && sts[EV_CMP] == 1, "R5", "fire at equal time", {armed, sts[EV_CMP]}, 1);
    set_tm(10, 600);
    wr(A_CLR, 32'h1);
    idle(2);
    chk(sts[EV_CMP] == 0, "R5", "one shot", sts[EV_CMP], 0);
    wr(A_TSEC, 11);
    wr(A_TNS, 900);
    set_tm(11, 100);
    wr(A_ARM, 1);
    idle(2);
    chk(sts[EV_CMP] == 0, "R5", "earlier ns", sts[EV_CMP], 0);
    set_tm(12, 0);
    idle(1);
    chk(sts[EV_CMP] == 1, "R5", "later seconds", sts[EV_CMP], 1);

    // R7 interrupt mask
    wr(A_IEN, 32'h0);
    chk(irq == 0, "R7", "masked", irq, 0);
    wr(A_IEN, 32'h1);
    chk(irq == 1, "R7", "enabled", irq, 1);
    wr(A_CLR, 32'h1);
    chk(irq == 0, "R7", "cleared", irq, 0);

    // R8/R9 pulse at 4 slots per second
    wr(A_CLR, 32'h7);
    wr(A_CFG, 32'h20);
    idle(2);
    step(12, 600000000, 0);
    step(12, 999999999, 0);
    step(20, 0, 1);
    step(20, 100000000, 0);
    step(20, 250000000, 1);
    step(20, 300000000, 0);
    step(20, 500000000, 1);
    step(20, 749999999, 0);
    step(20, 750000000, 1);
    step(20, 999999999, 0);
    step(21, 0, 1);
    step(21, 1, 0);
    chk(sts[EV_PPS] == 1, "R8", "pulse status", sts[EV_PPS], 1);

    idle(2);
    chk(exp_q.size() == 0, "R2", "missing snapshots", exp_q.size(), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule